// File: doc/BRIEF.md
# Memory Operand Effective Address Decoder

This block turns the addressing bytes of an instruction into a 32-bit memory offset. The bytes arrive one per clock on a stream with a valid/ready handshake. The first byte is the operand-addressing byte. A scale-index-base byte may follow it, and then a displacement of zero, one or four bytes. Eight 32-bit general register values are presented in parallel on one bus. The block combines the selected base register, an optional scaled index register and the displacement into the offset.

When the last byte of the form has been taken, the block raises a one-cycle done pulse. With that pulse it presents:
- the offset;
- the count of bytes it consumed;
- an invalid-encoding flag;
- a protection-fault flag.

The fault flag reports a write through a code-segment override while flat addressing is active. The stream is stalled for the duration of the pulse. The block then waits for the next addressing byte. Register values and the two mode inputs are sampled in the done cycle. The feeder is expected to hold them steady while a decode is in flight.

Top module: `ea_decoder`

## Requirements
- R1: The addressing byte is split as mod = bits 7:6, extension field = bits 5:3 and rm = bits 2:0. When rm is 4 and mod is not 3, exactly one scale-index-base byte follows (scale = bits 7:6, index = bits 5:3, base = bits 2:0). The reported length counts the addressing byte, the scale-index-base byte if present, and all displacement bytes.
- R2: mod 0 with rm 5 (no scale-index-base byte) yields a 4-byte displacement alone, with no register added, and a length of 5.
- R3: mod 1 adds one displacement byte, sign-extended. mod 2 adds a 4-byte displacement, least-significant byte first. mod 0 adds no displacement, except in the R2 and R6 forms.
- R4: Register number n (0..7) selects bits [32n+31:32n] of the register bus. The numbers map, in order, to the accumulator, counter, data, base, stack pointer, base pointer, source index and destination index. Without a scale-index-base byte, rm selects the base register.
- R5: With a scale-index-base byte, the offset is base register + (index register << scale) + displacement. An index of 4 adds no index term.
- R6: With a scale-index-base byte, mod 0 and base 5, no base register is added and a 4-byte displacement follows.
- R7: An index of 4 with a nonzero scale raises the invalid flag in the done cycle. The offset is still formed without an index term.
- R8: mod 3 raises the invalid flag with length 1 and offset 0. No further bytes are taken, and done follows in the cycle after the addressing byte is accepted.
- R9: The fault flag is high in the done cycle exactly when flat mode is on, bit 4 of the addressing byte is 1 and the code-segment override input is high.
- R10: Done is a single-cycle pulse. Ready is low during it. Outside done, the offset is 0 and both flags are 0.
- R11: After reset, ready is high and done is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| in_valid | input | 1 | Instruction byte valid |
| in_byte | input | 8 | Instruction byte |
| in_ready | output | 1 | Block accepts a byte this cycle |
| gpr_bus | input | 256 | Eight 32-bit register values, register n at bits [32n+31:32n] |
| flat_mode | input | 1 | Flat (non-segmented) addressing active |
| cs_override | input | 1 | Code-segment override prefix present |
| ea_done | output | 1 | One-cycle result strobe |
| ea_offset | output | 32 | Effective offset |
| ea_len | output | 3 | Instruction bytes consumed |
| ea_invalid | output | 1 | Illegal encoding |
| ea_fault | output | 1 | Protection fault |

## Verification
Every mod/rm pair is tried with distinct values in all eight registers. A negative and a positive first displacement byte are used, so that a wrong register choice, a lost sign extension and a wrong byte order each give a different offset.

All 256 scale-index-base bytes are run under mods 0 to 2. This separates the scaled index sum, the missing-index case and the missing-base case, and it catches an illegal scale that goes unflagged. All eight combinations of flat mode, write bit and override are checked for the fault. Some decodes are sent with idle gaps in the byte stream, to show that length and byte order depend on accepted bytes rather than on cycles.

// File: rtl/ea_pkg.sv
package ea_pkg;
  localparam int NREG  = 8;
  localparam int RSEL_W = $clog2(NREG);

  typedef enum logic [1:0] {
    ST_MODRM = 2'd0,
    ST_SIB   = 2'd1,
    ST_DISP  = 2'd2,
    ST_DONE  = 2'd3
  } ea_state_e;

  typedef struct packed {
    logic [RSEL_W-1:0] base_sel;
    logic              base_en;
    logic [RSEL_W-1:0] idx_sel;
    logic              idx_en;
    logic [1:0]        scale;
    logic              bad_mode;
    logic              bad_scale;
  } ea_fields_t;
endpackage

// File: rtl/ea_stream_seq.sv
module ea_stream_seq
  import ea_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [7:0]       in_byte,
  output logic             in_ready,
  output logic             done,
  output logic [1:0]       mod_q,
  output logic [2:0]       rm_q,
  output logic             wr_q,
  output logic [7:0]       sib_q,
  output logic             has_sib_q,
  output logic [AW-1:0]    disp_q,
  output logic [LEN_W-1:0] dlen_q,
  output logic [LEN_W-1:0] len_q,
  output logic             modrm_take
);
  localparam int DISP_N = AW / 8;

  ea_state_e        st_q, st_d;
  logic             take;
  logic [LEN_W-1:0] dl_now;
  logic [LEN_W-1:0] cnt_q;

  // displacement byte count implied by mod and the low field (rm or base)
  function automatic logic [LEN_W-1:0] disp_len_f(input logic [1:0] m,
                                                  input logic [2:0] low);
    case (m)
      2'd1:    return LEN_W'(1);
      2'd2:    return LEN_W'(DISP_N);
      2'd0:    return (low == 3'd5) ? LEN_W'(DISP_N) : '0;
      default: return '0;
    endcase
  endfunction

  assign in_ready   = (st_q != ST_DONE);
  assign done       = (st_q == ST_DONE);
  assign take       = in_valid && in_ready;
  assign modrm_take = take && (st_q == ST_MODRM);
  assign dl_now     = (st_q == ST_MODRM) ? disp_len_f(in_byte[7:6], in_byte[2:0])
                                         : disp_len_f(mod_q, in_byte[2:0]);

  always_comb begin
    st_d = st_q;
    case (st_q)
      ST_MODRM: if (take) begin
        if (in_byte[7:6] == 2'd3)       st_d = ST_DONE;
        else if (in_byte[2:0] == 3'd4)  st_d = ST_SIB;
        else if (dl_now != '0)          st_d = ST_DISP;
        else                            st_d = ST_DONE;
      end
      ST_SIB: if (take) st_d = (dl_now != '0) ? ST_DISP : ST_DONE;
      ST_DISP: if (take && ((cnt_q + LEN_W'(1)) == dlen_q)) st_d = ST_DONE;
      default: st_d = ST_MODRM;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q      <= ST_MODRM;
      mod_q     <= '0;
      rm_q      <= '0;
      wr_q      <= 1'b0;
      sib_q     <= '0;
      has_sib_q <= 1'b0;
      disp_q    <= '0;
      dlen_q    <= '0;
      len_q     <= '0;
      cnt_q     <= '0;
    end else begin
      st_q <= st_d;
      if (take) begin
        case (st_q)
          ST_MODRM: begin
            mod_q     <= in_byte[7:6];
            wr_q      <= in_byte[4];
            rm_q      <= in_byte[2:0];
            has_sib_q <= 1'b0;
            sib_q     <= '0;
            disp_q    <= '0;
            cnt_q     <= '0;
            len_q     <= LEN_W'(1);
            dlen_q    <= (in_byte[2:0] == 3'd4) ? '0 : dl_now;
          end
          ST_SIB: begin
            sib_q     <= in_byte;
            has_sib_q <= 1'b1;
            dlen_q    <= dl_now;
            len_q     <= len_q + LEN_W'(1);
          end
          ST_DISP: begin
            // shift in from the top: first byte ends lowest after DISP_N bytes
            disp_q <= {in_byte, disp_q[AW-1:8]};
            cnt_q  <= cnt_q + LEN_W'(1);
            len_q  <= len_q + LEN_W'(1);
          end
          default: ;
        endcase
      end
    end
  end
endmodule

// File: rtl/ea_field_decode.sv
module ea_field_decode
  import ea_pkg::*;
(
  input  logic [1:0] mod_i,
  input  logic [2:0] rm_i,
  input  logic [7:0] sib_i,
  input  logic       has_sib_i,
  output ea_fields_t fields
);
  logic [1:0] sc;
  logic [2:0] ix, bs;

  assign sc = sib_i[7:6];
  assign ix = sib_i[5:3];
  assign bs = sib_i[2:0];

  always_comb begin
    fields          = '0;
    fields.bad_mode = (mod_i == 2'd3);
    if (has_sib_i) begin
      fields.base_sel  = bs;
      fields.base_en   = !((mod_i == 2'd0) && (bs == 3'd5));
      fields.idx_sel   = ix;
      fields.idx_en    = (ix != 3'd4);
      fields.scale     = sc;
      fields.bad_scale = (ix == 3'd4) && (sc != 2'd0);
    end else begin
      fields.base_sel = rm_i;
      fields.base_en  = !((mod_i == 2'd0) && (rm_i == 3'd5)) && (mod_i != 2'd3);
    end
  end
endmodule

// File: rtl/ea_addr_calc.sv
module ea_addr_calc
  import ea_pkg::*;
#(
  parameter int AW    = 32,
  parameter int LEN_W = 3
) (
  input  logic [NREG*AW-1:0] gpr_bus,
  input  ea_fields_t         fields,
  input  logic [AW-1:0]      disp_q,
  input  logic [LEN_W-1:0]   dlen_q,
  output logic [AW-1:0]      sum
);
  function automatic logic [AW-1:0] pick_reg(input logic [NREG*AW-1:0] bus,
                                             input logic [RSEL_W-1:0] sel);
    return bus[sel*AW +: AW];
  endfunction

  function automatic logic [AW-1:0] disp_ext(input logic [AW-1:0] d,
                                             input logic [LEN_W-1:0] n);
    if (n == LEN_W'(1)) return {{(AW-8){d[AW-1]}}, d[AW-1 -: 8]};
    return d;
  endfunction

  logic [AW-1:0] base_term, idx_term;

  assign base_term = fields.base_en ? pick_reg(gpr_bus, fields.base_sel) : '0;
  assign idx_term  = fields.idx_en ? (pick_reg(gpr_bus, fields.idx_sel) << fields.scale) : '0;
  assign sum       = base_term + idx_term + disp_ext(disp_q, dlen_q);
endmodule

// File: rtl/ea_decoder.sv
module ea_decoder
  import ea_pkg::*;
#(
  parameter int AW = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  input  logic [7:0]         in_byte,
  output logic               in_ready,
  input  logic [NREG*AW-1:0] gpr_bus,
  input  logic               flat_mode,
  input  logic               cs_override,
  output logic               ea_done,
  output logic [AW-1:0]      ea_offset,
  output logic [2:0]         ea_len,
  output logic               ea_invalid,
  output logic               ea_fault
);
  localparam int LEN_W = 3;

  logic             done;
  logic [1:0]       mod_q;
  logic [2:0]       rm_q;
  logic             wr_q;
  logic [7:0]       sib_q;
  logic             has_sib_q;
  logic [AW-1:0]    disp_q;
  logic [LEN_W-1:0] dlen_q, len_q;
  logic             modrm_take;
  ea_fields_t       fields;
  logic [AW-1:0]    sum;

  ea_stream_seq #(.AW(AW), .LEN_W(LEN_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .done(done), .mod_q(mod_q), .rm_q(rm_q), .wr_q(wr_q),
    .sib_q(sib_q), .has_sib_q(has_sib_q), .disp_q(disp_q), .dlen_q(dlen_q),
    .len_q(len_q), .modrm_take(modrm_take)
  );

  ea_field_decode u_dec (
    .mod_i(mod_q), .rm_i(rm_q), .sib_i(sib_q), .has_sib_i(has_sib_q), .fields(fields)
  );

  ea_addr_calc #(.AW(AW), .LEN_W(LEN_W)) u_calc (
    .gpr_bus(gpr_bus), .fields(fields), .disp_q(disp_q), .dlen_q(dlen_q), .sum(sum)
  );

  assign ea_done    = done;
  assign ea_len     = done ? len_q : '0;
  assign ea_offset  = (done && !fields.bad_mode) ? sum : '0;
  assign ea_invalid = done && (fields.bad_mode || fields.bad_scale);
  assign ea_fault   = done && flat_mode && wr_q && cs_override;
endmodule

// File: rtl/ea_decoder_chk.sv
module ea_decoder_chk #(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic [7:0]    in_byte,
  input logic          in_ready,
  input logic          flat_mode,
  input logic          cs_override,
  input logic          ea_done,
  input logic [AW-1:0] ea_offset,
  input logic [2:0]    ea_len,
  input logic          ea_invalid,
  input logic          ea_fault,
  input logic          modrm_take
);
  // R10
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_done |=> !ea_done);

  // R10
  ready_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_done |-> !in_ready);

  // R10
  quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ea_done |-> (!ea_invalid && !ea_fault && ea_offset == '0));

  // R8
  reg_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (modrm_take && in_byte[7:6] == 2'b11) |=> (ea_done && ea_invalid && ea_len == 3'd1));

  // R1
  len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_done |-> (ea_len >= 3'd1 && ea_len <= 3'd6));

  // R9
  fault_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ea_fault |-> (flat_mode && cs_override));
endmodule

bind ea_decoder ea_decoder_chk #(.AW(AW)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_byte(in_byte), .in_ready(in_ready),
  .flat_mode(flat_mode), .cs_override(cs_override), .ea_done(ea_done),
  .ea_offset(ea_offset), .ea_len(ea_len), .ea_invalid(ea_invalid),
  .ea_fault(ea_fault), .modrm_take(modrm_take)
);

// File: tb/ea_decoder_tb.sv
module ea_decoder_tb;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic [7:0]   in_byte = '0;
  logic         in_ready;
  logic [255:0] gpr_bus;
  logic         flat_mode = 1'b1;
  logic         cs_override = 1'b0;
  logic         ea_done;
  logic [31:0]  ea_offset;
  logic [2:0]   ea_len;
  logic         ea_invalid;
  logic         ea_fault;

  int checks = 0;
  int errors = 0;
  int cycles = 0;

  logic [31:0] regs [8];
  logic [7:0]  tx_b [8];

  always #10 clk = ~clk;

  always_comb
    for (int i = 0; i < 8; i++) gpr_bus[i*32 +: 32] = regs[i];

  ea_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_byte(in_byte),
    .in_ready(in_ready), .gpr_bus(gpr_bus), .flat_mode(flat_mode),
    .cs_override(cs_override), .ea_done(ea_done), .ea_offset(ea_offset),
    .ea_len(ea_len), .ea_invalid(ea_invalid), .ea_fault(ea_fault)
  );

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // bench model: expected offset, length and invalid from tx_b and regs
  task automatic model(output logic [31:0] eo, output int el, output logic ei,
                       output string tag);
    logic [1:0] md; logic [2:0] r; int p; int nd;
    logic [1:0] sc; logic [2:0] ix, bs;
    md = tx_b[0][7:6]; r = tx_b[0][2:0];
    eo = 0; ei = 0; p = 1; nd = 0; tag = "R4";
    if (md == 2'd3) begin
      el = 1; ei = 1; tag = "R8";
      return;
    end
    if (r == 3'd4) begin
      sc = tx_b[1][7:6]; ix = tx_b[1][5:3]; bs = tx_b[1][2:0];
      p = 2; tag = "R5";
      if (ix == 3'd4) begin
        if (sc != 0) begin ei = 1; tag = "R7"; end
      end else
        eo = eo + regs[ix] * (sc == 0 ? 32'd1 : sc == 1 ? 32'd2 : sc == 2 ? 32'd4 : 32'd8);
      if (md == 0 && bs == 3'd5) tag = "R6";
      else eo = eo + regs[bs];
      nd = (md == 1) ? 1 : ((md == 2 || bs == 3'd5) ? 4 : 0);
    end else if (md == 0 && r == 3'd5) begin
      nd = 4; tag = "R2";
    end else begin
      eo = eo + regs[r];
      nd = (md == 1) ? 1 : (md == 2) ? 4 : 0;
      if (md != 0) tag = "R3";
    end
    if (nd == 1) eo = eo + {{24{tx_b[p][7]}}, tx_b[p]};
    if (nd == 4) eo = eo + {tx_b[p+3], tx_b[p+2], tx_b[p+1], tx_b[p]};
    el = p + nd;
  endtask

  task automatic run_txn(input bit gaps);
    logic [31:0] eo; int el; logic ei; string tag; logic ef;
    model(eo, el, ei, tag);
    ef = flat_mode && tx_b[0][4] && cs_override;
    for (int k = 0; k < el; k++) begin
      if (gaps && k > 0) begin
        @(negedge clk); in_valid = 1'b0; in_byte = 8'hEE;
      end
      @(negedge clk); in_valid = 1'b1; in_byte = tx_b[k];
    end
    @(negedge clk); in_valid = 1'b0; in_byte = 8'h00;
    chk("R10", "done", 32'(ea_done), 32'd1);
    chk("R10", "ready in done", 32'(in_ready), 32'd0);
    chk(tag, "offset", ea_offset, eo);
    chk("R1", "length", 32'(ea_len), 32'(el));
    chk(ei && tag == "R8" ? "R8" : (tag == "R7" ? "R7" : "R1"), "invalid",
        32'(ea_invalid), 32'(ei));
    chk("R9", "fault", 32'(ea_fault), 32'(ef));
    @(negedge clk);
    chk("R10", "done pulse", 32'(ea_done), 32'd0);
    chk("R10", "quiet offset", ea_offset, 32'd0);
  endtask

  initial begin
    for (int i = 0; i < 8; i++)
      regs[i] = 32'(i + 1) * 32'h1111_1111 + 32'(i) * 32'h0234_5000;
    for (int i = 0; i < 8; i++) tx_b[i] = 8'h00;
    repeat (3) @(negedge clk);
    chk("R11", "ready after reset", 32'(in_ready), 32'd1);
    chk("R11", "done after reset", 32'(ea_done), 32'd0);
    rst_n = 1'b1;
    @(negedge clk);

    // plain forms: every mod/rm, two displacement patterns
    for (int md = 0; md < 4; md++)
      for (int r = 0; r < 8; r++)
        for (int pt = 0; pt < 2; pt++) begin
          if (r == 4 && md != 3) continue;
          tx_b[0] = {2'(md), 3'(pt * 5 + r), 3'(r)};
          tx_b[0][4] = 1'b0;
          tx_b[1] = pt ? 8'h85 : 8'h7A;
          tx_b[2] = 8'hC3; tx_b[3] = 8'h5E; tx_b[4] = pt ? 8'h91 : 8'h02;
          run_txn(pt == 1 && r < 3);
        end

    // scale-index-base byte sweep
    for (int md = 0; md < 3; md++)
      for (int s = 0; s < 256; s++) begin
        tx_b[0] = {2'(md), 3'b000, 3'd4};
        tx_b[1] = 8'(s);
        tx_b[2] = 8'(s) ^ 8'hA5; tx_b[3] = 8'h3C; tx_b[4] = 8'(md * 40); tx_b[5] = 8'hF0;
        run_txn(s % 37 == 0);
      end

    // fault combinations
    for (int f = 0; f < 8; f++) begin
      flat_mode   = f[0];
      cs_override = f[1];
      tx_b[0] = {2'b01, 1'b0, f[2], 4'b0011};
      tx_b[1] = 8'hF8;
      run_txn(1'b0);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule